// File: doc/BRIEF.md
# USB Power Delivery Frame Transmitter (BMC Line Encoder)

This block puts one USB Power Delivery frame onto the CC line as a biphase-mark-coded bit stream. A half-bit tick is derived from the 16 MHz system clock by a divide-by-27 counter, which gives about 1.687 µs per half bit. The counter restarts whenever a frame is accepted, so every line event lands a fixed number of clock cycles after the start strobe.

A frame is requested with a one-cycle start strobe and a 3-bit frame-type code. The block first holds the line idle for the inter-frame gap. It then sends a 64-bit alternating preamble, followed by the four K-code symbols of the selected ordered set. For message types it next pulls 5-bit payload symbols from a valid/ready stream, already coded by an upstream stage, and closes the frame with the end-of-packet symbol. The two reset types end right after the ordered set. When the frame ends, the line returns to idle low, the driver enable drops, and a one-cycle done pulse is raised. If the stream has nothing to offer when a payload symbol is due, the frame is cut short and an underrun flag is raised.

Top module: `pd_bmc_tx`

## Requirements
- R1: After reset, `line_out`, `line_drive_en`, `frame_done`, `sym_ready` and `underrun` are all 0.
- R2: Once a start is accepted, the line stays low with the driver disabled for 17 half-bit ticks, the inter-frame gap.
- R3: Half-bit tick n falls on clock edge 27·n counted from the edge that accepted the start, and all line activity happens on those edges.
- R4: Each bit lasts two half-bit ticks. The line toggles at the start of every bit, and toggles again at mid-bit only when the bit is 1.
- R5: The first 64 bits of every frame alternate, starting with 0.
- R6: The frame-type code selects the ordered set from these 5-bit K-codes: Sync-1 0x18, Sync-2 0x11, Sync-3 0x06, RST-1 0x07, RST-2 0x19. Code 0 sends S1 S1 S1 S2. Code 1 sends S1 S1 S3 S3. Code 2 sends S1 S3 S1 S3. Code 3 sends S1 R2 R2 S3. Code 4 sends S1 R2 S3 S2. Code 5 sends R1 R1 R1 R2. Code 6 sends R1 S1 R1 S3.
- R7: The symbols of the ordered set go out in the listed order, and each 5-bit symbol is sent least significant bit first.
- R8: For codes 0 to 4, payload symbols follow the ordered set. Each symbol is taken when `sym_ready` and `sym_valid` are both high, on the tick that starts its first bit. After the symbol marked `sym_last`, the end-of-packet symbol 0x0D is sent.
- R9: For codes 5 and 6, the frame ends right after the ordered set. `sym_ready` never rises, and no payload or end-of-packet symbol is sent.
- R10: A frame of N bits ends at tick 17 + 2N. On that edge `line_out` and `line_drive_en` go low, and `frame_done` is high for exactly one cycle.
- R11: If `sym_valid` is low when a payload symbol is due, the frame ends on that tick as in R10 and `underrun` is set. `underrun` stays set until the next start is accepted.
- R12: A start that arrives while a frame is in progress is ignored. A start with code 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle frame request |
| frame_type | input | 3 | Ordered-set select, codes 0 to 6 |
| sym_data | input | 5 | Coded payload symbol, LSB sent first |
| sym_valid | input | 1 | Payload symbol available |
| sym_last | input | 1 | Marks the final payload symbol |
| sym_ready | output | 1 | Payload symbol taken this cycle |
| line_out | output | 1 | BMC line level |
| line_drive_en | output | 1 | Line driver enable |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| underrun | output | 1 | Frame was cut short for lack of payload |

## Verification
All timing counts from the clock edge that accepts the start, edge k = 0. Tick n acts on edge 27·n. Bit b begins on tick 17 + 2b and reaches its mid point one tick later. The done pulse, the driver-enable fall and any underrun all appear together on edge 27·(17 + 2N). For every cycle of a frame, the bench works out the expected line level and enable from this arithmetic and a bit list it builds itself. It samples on the falling clock edge, so each registered change is seen in the same cycle index where the formula places it. It also checks the exact edge of the done pulse and how many symbols the stream handshake consumed.

// File: rtl/pd_tx_pkg.sv
package pd_tx_pkg;

  localparam int SYM_W     = 5;
  localparam int OSET_SYMS = 4;
  localparam int OSET_W    = SYM_W * OSET_SYMS;

  typedef logic [SYM_W-1:0] kcode_t;

  localparam kcode_t K_SYNC1 = 5'h18;
  localparam kcode_t K_SYNC2 = 5'h11;
  localparam kcode_t K_SYNC3 = 5'h06;
  localparam kcode_t K_RST1  = 5'h07;
  localparam kcode_t K_RST2  = 5'h19;
  localparam kcode_t K_EOP   = 5'h0D;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_PRE,
    ST_OSET,
    ST_DATA,
    ST_EOP,
    ST_TAIL
  } tx_state_t;

  // First symbol on the wire sits in the low bits.
  function automatic logic [OSET_W-1:0] pack_oset(kcode_t s0, kcode_t s1, kcode_t s2, kcode_t s3);
    return {s3, s2, s1, s0};
  endfunction

  function automatic logic [OSET_W-1:0] oset_word(logic [2:0] code);
    logic [OSET_W-1:0] w;
    unique case (code)
      3'd0:    w = pack_oset(K_SYNC1, K_SYNC1, K_SYNC1, K_SYNC2);
      3'd1:    w = pack_oset(K_SYNC1, K_SYNC1, K_SYNC3, K_SYNC3);
      3'd2:    w = pack_oset(K_SYNC1, K_SYNC3, K_SYNC1, K_SYNC3);
      3'd3:    w = pack_oset(K_SYNC1, K_RST2,  K_RST2,  K_SYNC3);
      3'd4:    w = pack_oset(K_SYNC1, K_RST2,  K_SYNC3, K_SYNC2);
      3'd5:    w = pack_oset(K_RST1,  K_RST1,  K_RST1,  K_RST2);
      3'd6:    w = pack_oset(K_RST1,  K_SYNC1, K_RST1,  K_SYNC3);
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic is_reset_code(logic [2:0] code);
    return (code == 3'd5) || (code == 3'd6);
  endfunction

  function automatic logic is_legal_code(logic [2:0] code);
    return code != 3'd7;
  endfunction

  function automatic logic is_tx_state(tx_state_t s);
    return (s == ST_PRE) || (s == ST_OSET) || (s == ST_DATA) || (s == ST_EOP);
  endfunction

endpackage

// File: rtl/pd_hbit_div.sv
module pd_hbit_div #(
  parameter int DIV = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R3

endmodule

// File: rtl/pd_bmc_line.sv
module pd_bmc_line (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_begin,
  input  logic bit_val,
  input  logic bit_mid,
  input  logic halt,
  output logic line,
  output logic drv_en
);
  logic held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line   <= 1'b0;
      drv_en <= 1'b0;
      held   <= 1'b0;
    end else if (halt) begin
      line   <= 1'b0;
      drv_en <= 1'b0;
      held   <= 1'b0;
    end else if (bit_begin) begin
      line   <= ~line;
      drv_en <= 1'b1;
      held   <= bit_val;
    end else if (bit_mid && held) begin
      line   <= ~line;
    end
  end

  AST_BIT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_begin && !halt) |=> (line != $past(line))); // R4
  AST_MID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_mid && !held && !halt && !bit_begin) |=> $stable(line)); // R4
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |-> !line); // R10

endmodule

// File: rtl/pd_frame_seq.sv
module pd_frame_seq
  import pd_tx_pkg::*;
#(
  parameter int IFG_TICKS     = 17,
  parameter int PREAMBLE_BITS = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       ftype,
  input  logic             tick,
  input  logic [SYM_W-1:0] sym_data,
  input  logic             sym_valid,
  input  logic             sym_last,
  output logic             sym_ready,
  output logic             run,
  output logic             bit_begin,
  output logic             bit_val,
  output logic             bit_mid,
  output logic             halt,
  output logic             done,
  output logic             underrun
);
  localparam int SPAN = (IFG_TICKS > PREAMBLE_BITS) ? IFG_TICKS : PREAMBLE_BITS;
  localparam int CW   = $clog2(SPAN + OSET_W + 1);
  localparam logic [CW-1:0] GAP_END  = CW'(IFG_TICKS - 1);
  localparam logic [CW-1:0] PRE_END  = CW'(PREAMBLE_BITS - 1);
  localparam logic [CW-1:0] OSET_END = CW'(OSET_W - 1);
  localparam logic [CW-1:0] SYM_END  = CW'(SYM_W - 1);

  tx_state_t         state;
  logic [CW-1:0]     cnt;
  logic              phase;
  logic [OSET_W-1:0] oset_sr;
  logic [SYM_W-1:0]  sym_sr;
  logic              last_q;
  logic              rst_q;

  logic accept, gap_last, in_tx, begin_evt, need_sym, starve, tail_evt;

  assign run       = (state != ST_IDLE);
  assign accept    = (state == ST_IDLE) && start && is_legal_code(ftype);
  assign gap_last  = (state == ST_GAP) && (cnt == GAP_END);
  assign in_tx     = is_tx_state(state);
  assign begin_evt = tick && (gap_last || (in_tx && !phase));
  assign need_sym  = (state == ST_DATA) && (cnt == '0);
  assign sym_ready = begin_evt && need_sym;
  assign starve    = sym_ready && !sym_valid;
  assign tail_evt  = tick && (state == ST_TAIL);
  assign halt      = starve || tail_evt;
  assign bit_begin = begin_evt && !starve;
  assign bit_mid   = tick && in_tx && phase;

  always_comb begin
    unique case (state)
      ST_PRE:  bit_val = cnt[0];
      ST_OSET: bit_val = oset_sr[0];
      ST_DATA: bit_val = need_sym ? sym_data[0] : sym_sr[0];
      ST_EOP:  bit_val = sym_sr[0];
      default: bit_val = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      phase    <= 1'b0;
      oset_sr  <= '0;
      sym_sr   <= '0;
      last_q   <= 1'b0;
      rst_q    <= 1'b0;
      done     <= 1'b0;
      underrun <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state    <= ST_GAP;
            cnt      <= '0;
            phase    <= 1'b0;
            oset_sr  <= oset_word(ftype);
            rst_q    <= is_reset_code(ftype);
            underrun <= 1'b0;
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_last) begin
              state <= ST_PRE;
              cnt   <= '0;
              phase <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: begin
          if (starve) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            phase    <= 1'b0;
            done     <= 1'b1;
            underrun <= 1'b1;
          end else if (begin_evt) begin
            phase <= 1'b1;
            if (need_sym) begin
              sym_sr <= sym_data;
              last_q <= sym_last;
            end
          end else if (bit_mid) begin
            phase <= 1'b0;
            unique case (state)
              ST_PRE: begin
                if (cnt == PRE_END) begin
                  state <= ST_OSET;
                  cnt   <= '0;
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end
              ST_OSET: begin
                oset_sr <= oset_sr >> 1;
                if (cnt == OSET_END) begin
                  cnt   <= '0;
                  state <= rst_q ? ST_TAIL : ST_DATA;
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end
              ST_DATA: begin
                if (cnt == SYM_END) begin
                  cnt <= '0;
                  if (last_q) begin
                    state  <= ST_EOP;
                    sym_sr <= K_EOP;
                  end
                end else begin
                  cnt    <= cnt + 1'b1;
                  sym_sr <= sym_sr >> 1;
                end
              end
              ST_EOP: begin
                sym_sr <= sym_sr >> 1;
                if (cnt == SYM_END) begin
                  cnt   <= '0;
                  state <= ST_TAIL;
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) sym_ready |-> tick); // R8
  AST_RESET_NO_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rst_q) |-> !sym_ready); // R9
  AST_UNDERRUN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> done); // R11
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !tick) |=> $stable(oset_sr)); // R12

endmodule

// File: rtl/pd_bmc_tx.sv
module pd_bmc_tx #(
  parameter int CLK_DIV       = 27,
  parameter int IFG_TICKS     = 17,
  parameter int PREAMBLE_BITS = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] frame_type,
  input  logic [4:0] sym_data,
  input  logic       sym_valid,
  input  logic       sym_last,
  output logic       sym_ready,
  output logic       line_out,
  output logic       line_drive_en,
  output logic       frame_done,
  output logic       underrun
);
  logic run, tick, bit_begin, bit_val, bit_mid, halt;

  pd_hbit_div #(.DIV(CLK_DIV)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  pd_frame_seq #(
    .IFG_TICKS    (IFG_TICKS),
    .PREAMBLE_BITS(PREAMBLE_BITS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .ftype    (frame_type),
    .tick     (tick),
    .sym_data (sym_data),
    .sym_valid(sym_valid),
    .sym_last (sym_last),
    .sym_ready(sym_ready),
    .run      (run),
    .bit_begin(bit_begin),
    .bit_val  (bit_val),
    .bit_mid  (bit_mid),
    .halt     (halt),
    .done     (frame_done),
    .underrun (underrun)
  );

  pd_bmc_line u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_begin(bit_begin),
    .bit_val  (bit_val),
    .bit_mid  (bit_mid),
    .halt     (halt),
    .line     (line_out),
    .drv_en   (line_drive_en)
  );

  AST_DRIVE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_en |-> run); // R2

endmodule

// File: tb/pd_bmc_tx_test.sv
module pd_bmc_tx_test;
  localparam int DIVN = 27;
  localparam int IFG  = 17;
  localparam int PREN = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] frame_type = 3'd0;
  logic [4:0] sym_data;
  logic sym_valid, sym_last, sym_ready;
  logic line_out, line_drive_en, frame_done, underrun;

  always #5 clk = ~clk;

  pd_bmc_tx uut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_type(frame_type),
    .sym_data(sym_data), .sym_valid(sym_valid), .sym_last(sym_last),
    .sym_ready(sym_ready), .line_out(line_out), .line_drive_en(line_drive_en),
    .frame_done(frame_done), .underrun(underrun)
  );

  // Payload source
  logic [4:0] pay [0:15];
  int navail = 0;
  bit term = 1'b0;
  bit idx_clr = 1'b0;
  int idx = 0;
  int taken = 0;

  assign sym_valid = (idx < navail);
  assign sym_data  = pay[idx[3:0]];
  assign sym_last  = term && (idx == navail - 1);

  always @(posedge clk) begin
    if (idx_clr) begin
      idx <= 0;
      taken <= 0;
    end else if (sym_ready && sym_valid) begin
      idx <= idx + 1;
      taken <= taken + 1;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit wd_fired = 1'b0;
  bit bseq [0:255];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [4:0] ksym(input int ft, input int p);
    logic [4:0] s1, s2, s3, r1, r2;
    logic [4:0] q [0:3];
    s1 = 5'h18; s2 = 5'h11; s3 = 5'h06; r1 = 5'h07; r2 = 5'h19;
    case (ft)
      0: q = '{s1, s1, s1, s2};
      1: q = '{s1, s1, s3, s3};
      2: q = '{s1, s3, s1, s3};
      3: q = '{s1, r2, r2, s3};
      4: q = '{s1, r2, s3, s2};
      5: q = '{r1, r1, r1, r2};
      default: q = '{r1, s1, r1, s3};
    endcase
    return q[p];
  endfunction

  task automatic run_frame(input int ft, input int nav, input bit trm, input bit poke, input int seed);
    int nb, end_tick, end_k, done_cnt, done_k;
    int m_gap, m_pre, m_os, m_pay, m_tail;
    bit msg, lev, exp_en, exp_line, exp_ur, ur_start;
    logic [4:0] sv;
    msg = (ft < 5);
    nb = 0;
    for (int i = 0; i < PREN; i++) begin bseq[nb] = i[0]; nb++; end
    for (int s = 0; s < 4; s++) begin
      sv = ksym(ft, s);
      for (int j = 0; j < 5; j++) begin bseq[nb] = sv[j]; nb++; end
    end
    for (int s = 0; s < 16; s++) pay[s] = 5'((seed * 7 + s * 11 + 3) % 32);
    if (msg) begin
      for (int s = 0; s < nav; s++)
        for (int j = 0; j < 5; j++) begin bseq[nb] = pay[s][j]; nb++; end
      if (trm) begin
        sv = 5'h0D;
        for (int j = 0; j < 5; j++) begin bseq[nb] = sv[j]; nb++; end
      end
    end
    exp_ur = msg && !trm;
    end_tick = IFG + 2 * nb;
    end_k = DIVN * end_tick;

    @(negedge clk);
    navail = nav; term = trm; idx_clr = 1'b1;
    frame_type = 3'(ft); start = 1'b1;
    @(negedge clk);
    start = 1'b0; idx_clr = 1'b0;
    lev = 1'b0; done_cnt = 0; done_k = -1;
    m_gap = 0; m_pre = 0; m_os = 0; m_pay = 0; m_tail = 0;
    ur_start = underrun;
    for (int k = 0; k <= end_k + 40; k++) begin
      int ticks, h, b;
      ticks = k / DIVN;
      if ((k % DIVN) == 0 && ticks >= IFG && ticks < end_tick) begin
        h = ticks - IFG;
        if (h % 2 == 0) lev = ~lev;
        else if (bseq[h / 2]) lev = ~lev;
      end
      exp_en = (ticks >= IFG) && (ticks < end_tick);
      exp_line = exp_en ? lev : 1'b0;
      if (line_out !== exp_line || line_drive_en !== exp_en) begin
        if (ticks < IFG) m_gap++;
        else if (ticks >= end_tick) m_tail++;
        else begin
          b = (ticks - IFG) / 2;
          if (b < PREN) m_pre++;
          else if (b < PREN + 20) m_os++;
          else m_pay++;
        end
      end
      if (frame_done === 1'b1) begin
        done_cnt++;
        done_k = k;
      end
      if (poke && k == 3000) begin start = 1'b1; frame_type = 3'd0; end
      if (poke && k == 3001) start = 1'b0;
      @(negedge clk);
    end
    chk(ur_start === 1'b0, "R11", "underrun clear after accept", int'(ur_start), 0);
    chk(m_gap == 0, "R2", "gap cycles with line or enable active (R3 timing)", m_gap, 0);
    chk(m_pre == 0, "R5", "preamble cycles mismatching BMC (R4)", m_pre, 0);
    chk(m_os == 0, "R6", "ordered-set cycles mismatching, LSB first (R7)", m_os, 0);
    if (msg) begin
      chk(m_pay == 0, "R8", "payload/EOP cycles mismatching", m_pay, 0);
      chk(taken == nav, "R8", "symbols consumed", taken, nav);
    end else begin
      chk(m_pay == 0 && taken == 0, "R9", "reset frame payload activity", taken + m_pay, 0);
    end
    chk(m_tail == 0 && done_cnt == 1 && done_k == end_k, "R10", "done edge", done_k, end_k);
    chk(underrun === exp_ur, "R11", "underrun flag", int'(underrun), int'(exp_ur));
    if (poke)
      chk(done_cnt == 1 && (m_pre + m_os + m_pay + m_tail) == 0, "R12",
          "frame disturbed by start while busy", done_cnt, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    wd_fired = 1'b1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(line_out === 1'b0, "R1", "line after reset", int'(line_out), 0);
    chk(line_drive_en === 1'b0, "R1", "enable after reset", int'(line_drive_en), 0);
    chk(frame_done === 1'b0 && sym_ready === 1'b0, "R1", "done/ready after reset", int'(frame_done), 0);
    chk(underrun === 1'b0, "R1", "underrun after reset", int'(underrun), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Code 7 must be ignored (R12)
    begin
      int act;
      act = 0;
      frame_type = 3'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < DIVN * (IFG + 4); k++) begin
        if (line_drive_en || line_out || frame_done || sym_ready) act++;
        @(negedge clk);
      end
      chk(act == 0, "R12", "activity after code 7 start", act, 0);
    end

    for (int ft = 0; ft < 7; ft++)
      run_frame(ft, (ft < 5) ? 2 : 3, 1'b1, ft == 1, ft);
    run_frame(0, 0, 1'b0, 1'b0, 9);
    run_frame(2, 4, 1'b1, 1'b0, 11);
    run_frame(4, 3, 1'b0, 1'b0, 12);
    run_frame(3, 1, 1'b1, 1'b0, 13);

    if (!wd_fired) begin
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule